// File: doc/BRIEF.md
# Opcode Prefix Decoder Stage

This stage sits between instruction fetch and decode in an 8-bit accumulator-style processor core. Fetched instruction bytes enter one at a time through a valid/ready handshake. A byte whose two low bits are both set belongs to one of the four opcode columns that the base instruction set leaves empty. The stage takes such a byte as a register prefix and does not issue it. It holds a 6-bit field built from that byte, and this field retargets the accumulator and index register of the next opcode only. That opcode is then issued at 16-bit data width.

A second kind of prefix is a single configurable "narrow" byte, 0x02 by default. It may stand directly ahead of a register prefix and returns the prefixed instruction to 8-bit width. Every opcode is issued with its accumulator selector, index selector, width flag and the number of prefix bytes it consumed. Each prefix byte costs one handshake cycle. Sequences that break the prefix rules raise a one-cycle error flag, and all pending prefix state is then dropped.

The stage adds no latency. An opcode byte passes to the output in the same cycle. A prefix byte is accepted whatever the downstream ready is.

Top module: `pfx_decode`

## Requirements
- R1: A byte with bits [1:0] = 2'b11, or equal to the narrow code (parameter, default 8'h02), is consumed as a prefix. It is accepted with in_ready high regardless of out_ready and never appears on the output.
- R2: A register prefix byte b yields the field {b[3:2], b[7:4]}. out_acc = b[3:2] (0 = A, 1 = X, 2 = Y, 3 = stack pointer) and out_idx = b[7:4] (index register R0..R15). Both apply to the next issued opcode.
- R3: An unprefixed opcode is issued in the same cycle with out_op equal to the input byte. It carries out_acc = 0, out_idx = 0, out_wide = 0 and out_extra = 0.
- R4: out_extra equals the number of prefix bytes that belong to the issued opcode: 0, 1 (register prefix) or 2 (narrow byte then register prefix).
- R5: An opcode following a single register prefix is issued with out_wide = 1.
- R6: An opcode following the narrow byte and then a register prefix is issued with out_wide = 0 and the register prefix's selectors.
- R7: Prefix state is one-shot. The opcode issued after a prefixed opcode carries the defaults unless it has prefixes of its own.
- R8: Any prefix byte that arrives while a register prefix is pending (with or without the narrow byte) pulses seq_err for that cycle. The byte is consumed, all pending state is dropped, and nothing is issued for it.
- R9: A narrow byte that is followed by an opcode or by a second narrow byte pulses seq_err and drops pending state. A following opcode is still issued, with the defaults and out_extra = 0.
- R10: When out_ready is low and the input byte is an opcode, out_valid stays high, in_ready is low and the pending prefix state is kept.
- R11: Reset (active-low rst_n) clears pending prefix state, so the first opcode after reset carries the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetched byte valid |
| in_byte | input | 8 | Fetched instruction byte |
| in_ready | output | 1 | Stage accepts the byte this cycle |
| out_valid | output | 1 | Opcode issued this cycle |
| out_ready | input | 1 | Decoder accepts the issued opcode |
| out_op | output | 8 | Issued opcode byte |
| out_acc | output | 2 | Accumulator selector |
| out_idx | output | 4 | Index register selector |
| out_wide | output | 1 | 1 = 16-bit data, 0 = 8-bit |
| out_extra | output | 2 | Prefix bytes consumed by this opcode |
| seq_err | output | 1 | Illegal prefix sequence seen this cycle |

## Verification
The assertions check properties that hold on every cycle. Prefix bytes never reach the output and are always accepted. An opcode issued with no prefix count always carries the defaults. Width agrees with the prefix count, a back-to-back issue is never prefixed, and a stall blocks the input. The mapping of bits into selectors, the one-shot clearing, both illegal orderings, and the clearing by a reset that lands mid-sequence are sequence-dependent. Only the bench's cycle-by-cycle model over directed and pseudo-random byte streams can show those.

// File: rtl/pfx_decode.sv
module pfx_decode #(
  parameter logic [7:0] NARROW_CODE = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_op,
  output logic [1:0] out_acc,
  output logic [3:0] out_idx,
  output logic       out_wide,
  output logic [1:0] out_extra,
  output logic       seq_err
);

  typedef enum logic [1:0] {S_IDLE, S_REG, S_NAR, S_NREG} state_t;

  state_t     state;
  logic [5:0] field;

  logic is_reg, is_nar, is_pfx, has_field, take_pfx, take_op;

  assign is_reg    = (in_byte[1:0] == 2'b11);
  assign is_nar    = (in_byte == NARROW_CODE);
  assign is_pfx    = is_reg | is_nar;
  assign has_field = (state == S_REG) || (state == S_NREG);

  assign in_ready  = is_pfx | out_ready;
  assign out_valid = in_valid & ~is_pfx;
  assign out_op    = in_byte;
  assign out_acc   = has_field ? field[5:4] : 2'd0;
  assign out_idx   = has_field ? field[3:0] : 4'd0;
  assign out_wide  = (state == S_REG);
  assign out_extra = (state == S_REG) ? 2'd1 : (state == S_NREG) ? 2'd2 : 2'd0;

  assign take_pfx  = in_valid & is_pfx;
  assign take_op   = in_valid & ~is_pfx & out_ready;

  assign seq_err = in_valid & ((is_pfx & has_field) |
                   ((state == S_NAR) & (is_nar | (~is_pfx & out_ready))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      field <= '0;
    end else if (take_pfx) begin
      case (state)
        S_IDLE: begin
          state <= is_reg ? S_REG : S_NAR;
          if (is_reg) field <= {in_byte[3:2], in_byte[7:4]};
        end
        S_NAR: begin
          state <= is_reg ? S_NREG : S_IDLE;
          if (is_reg) field <= {in_byte[3:2], in_byte[7:4]};
        end
        default: state <= S_IDLE;
      endcase
    end else if (take_op) begin
      state <= S_IDLE;
    end
  end

endmodule

// File: rtl/pfx_decode_chk.sv
module pfx_decode_chk #(
  parameter logic [7:0] NARROW_CODE = 8'h02
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_acc,
  input logic [3:0] out_idx,
  input logic       out_wide,
  input logic [1:0] out_extra,
  input logic       seq_err
);

  AST_PFX_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_byte[1:0] != 2'b11 && in_byte != NARROW_CODE)); // R1

  AST_PFX_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte[1:0] == 2'b11) |-> in_ready); // R1

  AST_DEFAULT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_extra == 2'd0) |-> (out_acc == 2'd0 && out_idx == 4'd0 && !out_wide)); // R3

  AST_EXTRA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_extra != 2'd3); // R4

  AST_WIDE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_extra == 2'd1) |-> out_wide); // R5

  AST_NARROW_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_extra == 2'd2) |-> !out_wide); // R6

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid && out_ready) && out_valid) |-> out_extra == 2'd0); // R7

  AST_ERR_NO_PREFIXED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !(out_valid && out_extra != 2'd0)); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10

endmodule

bind pfx_decode pfx_decode_chk #(.NARROW_CODE(NARROW_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_acc(out_acc), .out_idx(out_idx), .out_wide(out_wide),
  .out_extra(out_extra), .seq_err(seq_err)
);

// File: tb/pfx_decode_tb_top.sv
`timescale 1ns/1ps
module pfx_decode_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'hEA;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_wide, seq_err;
  logic [7:0] out_op;
  logic [1:0] out_acc, out_extra;
  logic [3:0] out_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfx_decode dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_acc(out_acc), .out_idx(out_idx),
    .out_wide(out_wide), .out_extra(out_extra), .seq_err(seq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int         ms = 0;
  logic [5:0] mf = '0;
  bit         last_pf = 0;
  logic [7:0] q[$];

  task automatic step(input bit v, input bit r);
    bit pfx, nw, ev, erdy, eerr, ewide;
    logic [1:0] eacc, eext;
    logic [3:0] eidx;
    int nxt;
    logic [5:0] nf;
    logic [7:0] b;
    @(negedge clk);
    b = (q.size() > 0) ? q[0] : 8'hEA;
    in_valid = v; in_byte = b; out_ready = r;
    #1;
    pfx = (b[1:0] == 2'b11); nw = (b == 8'h02);
    ev = v && !(pfx || nw); erdy = pfx || nw || r;
    eacc = 0; eidx = 0; ewide = 0; eext = 0; eerr = 0; nxt = ms; nf = mf;
    case (ms)
      0: if (v && pfx) begin nxt = 1; nf = {b[3:2], b[7:4]}; end
         else if (v && nw) nxt = 2;
      1: if (v && (pfx || nw)) begin eerr = 1; nxt = 0; end
         else begin eacc = mf[5:4]; eidx = mf[3:0]; ewide = 1; eext = 1; if (ev && r) nxt = 0; end
      2: if (v && pfx) begin nxt = 3; nf = {b[3:2], b[7:4]}; end
         else if (v && nw) begin eerr = 1; nxt = 0; end
         else if (ev && r) begin eerr = 1; nxt = 0; end
      default: if (v && (pfx || nw)) begin eerr = 1; nxt = 0; end
         else begin eacc = mf[5:4]; eidx = mf[3:0]; eext = 2; if (ev && r) nxt = 0; end
    endcase
    chk(in_ready == erdy, "R10 in_ready", in_ready, erdy);
    chk(out_valid == ev, "R1 out_valid", out_valid, ev);
    chk(seq_err == eerr, (ms == 2) ? "R9 seq_err" : "R8 seq_err", seq_err, eerr);
    if (ev) begin
      chk(out_op == b, "R3 out_op", out_op, b);
      chk({out_acc, out_idx} == {eacc, eidx}, (eext == 0 && last_pf) ? "R7 selectors" : "R2 selectors",
          {out_acc, out_idx}, {eacc, eidx});
      chk(out_wide == ewide, (eext == 2) ? "R6 out_wide" : "R5 out_wide", out_wide, ewide);
      chk(out_extra == eext, "R4 out_extra", out_extra, eext);
      if (r) last_pf = (eext != 0);
    end
    ms = nxt; mf = nf;
    if (v && (erdy) && q.size() > 0) void'(q.pop_front());
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed = 12345;
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid == 0, "R11 reset out_valid", out_valid, 0);
    chk(seq_err == 0, "R11 reset seq_err", seq_err, 0);
    rst_n = 1'b1;

    q = '{8'hA9, 8'h13, 8'hB1, 8'hA5, 8'h02, 8'h3F, 8'h91, 8'h60,
          8'h13, 8'h17, 8'hEA, 8'h02, 8'hEA, 8'h02, 8'h02, 8'hEA,
          8'h47, 8'h02, 8'hEA, 8'h02, 8'h6B, 8'h1F, 8'h02, 8'hEA,
          8'hFB, 8'h85, 8'h85};
    while (q.size() > 0) step(1'b1, 1'b1);

    q = '{8'h8F, 8'hB1, 8'h02, 8'hCB, 8'h91};
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    while (q.size() > 0) step(1'b1, 1'b1);

    q = '{8'h57};
    step(1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ms = 0;
    q = '{8'hA9};
    step(1'b1, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [7:0] b;
      seed = seed * 1103515245 + 12345;
      k = (seed >>> 16) & 32'h7FFF;
      b = k[7:0];
      if (k[10:8] == 3'd0) b = 8'h02;
      else if (k[10:8] < 3'd4) b[1:0] = 2'b11;
      else if (b[1:0] == 2'b11 || b == 8'h02) b[1:0] = 2'b01;
      q.push_back(b);
    end
    while (q.size() > 0) begin
      int k;
      seed = seed * 1103515245 + 12345;
      k = (seed >>> 16) & 32'h7FFF;
      step(k[1:0] != 2'd0, k[3:2] != 2'd0);
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule